// File: doc/BRIEF.md
# SDRAM Address Mapper with Open-Row Tracker

This block sits between a host that issues flat word addresses and the command sequencer of an SDRAM controller. Each accepted address is split into a column, an internal bank and a row. The split follows two configuration inputs: a page-size code (256, 512, 1024 or 2048 words) and a two-bank/four-bank selector. The bank field lies directly above the column field, so consecutive pages walk through every internal bank before the row advances. The fields are registered one cycle after the request.

From the registered fields and the command the sequencer is presenting, the block drives the multiplexed address pins, the separately controlled auto-precharge line, and two bank-select lines. It also remembers which bank and row were last opened. Each access is classified as a hit (same bank and same row as the open one) or a miss. A change of bank and a change of row count as the same miss. A separate flag marks an access whose address is the previous address plus one within the same page. The block issues no commands and counts no timing; the sequencer decides what to do with the flags.

Top module: `sdram_page_mapper`

## Requirements
- R1: One cycle after a request, `colOut` holds the low 8+`cfgPageSel` address bits (page code 0..3 = 256, 512, 1024, 2048 words), and its higher bits are zero.
- R2: `bankOut` holds the address bits directly above the column: two bits with `cfgFourBanks`=1, otherwise one bit with `bankOut[1]`=0. Bank index 0..3 names banks A..D.
- R3: `rowOut` holds the 13 address bits directly above the bank field; address bits above those are dropped.
- R4: During ACT, RD and WR, `pinBankLo` carries bank bit 0 and `pinBankHi` carries bank bit 1 (always 0 in two-bank mode). During every other command both lines are low.
- R5: During ACT (1) and MRS (6), `pinAddr` carries the row with bit 10 forced low, and `pinA10` carries row bit 10. `pinAddr[10]` is low under every command.
- R6: During RD (2) and WR (3), column bits 9..0 appear on `pinAddr[9:0]`, column bit 10 appears on `pinAddr[11]`, `pinAddr[12]` and `pinAddr[10]` are low, and `pinA10` is low.
- R7: During PREA (4), `pinA10` is high while `pinAddr` and the bank lines are low. During NOP (0) and REF (5), all address, A10 and bank lines are low.
- R8: An accepted request raises `hit` when a row is open and both its bank and row equal the open ones; otherwise it raises `miss`. An ACT opens the bank and row of the most recently captured request. `hit` and `miss` are never high together, and both are low when `accValid` is low.
- R9: After a PREA or REF, the next request reports `miss` until an ACT opens a row again.
- R10: `seq` rises when the address equals the previous request's address plus one and both lie in the same page. A wrap from the last word of a page back to its first word stays a hit but is not sequential.
- R11: The configuration inputs take effect only in cycles where `ctrlIdle` is high. Changes while it is low leave the field split unchanged.
- R12: After reset `accValid`, `hit`, `miss` and `seq` are low, no row is open, and all pins are low under NOP. `accValid` is high exactly in the cycle after `reqValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPageSel | input | 2 | Page size code: 0=256, 1=512, 2=1024, 3=2048 words |
| cfgFourBanks | input | 1 | 1 = four internal banks, 0 = two |
| ctrlIdle | input | 1 | Sequencer idle; configuration is sampled while high |
| reqValid | input | 1 | Capture `reqAddr` this cycle |
| reqAddr | input | 26 | Flat word address |
| cmd | input | 3 | Command being presented: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PREA, 5 REF, 6 MRS |
| accValid | output | 1 | Registered fields and flags are valid |
| colOut | output | 11 | Column field |
| rowOut | output | 13 | Row field |
| bankOut | output | 2 | Bank field |
| hit | output | 1 | Access falls in the open bank and row |
| miss | output | 1 | Access needs a new row (other bank or other row) |
| seq | output | 1 | Address is previous plus one in the same page |
| pinAddr | output | 13 | Multiplexed address pins (bit 10 unused) |
| pinA10 | output | 1 | Auto-precharge / row bit 10 line |
| pinBankLo | output | 1 | Bank-select line for bank bit 0 |
| pinBankHi | output | 1 | Bank-select line for bank bit 1 |

## Verification
The assertions assume that `cmd` only takes the seven listed codes and that an ACT follows a captured request, so the open bank and row are meaningful. They also assume a request never lands in the same cycle as the ACT that should open its row. The bench keeps to this by driving one action per cycle: a request, then a command, each separated by an edge. It changes the configuration only with `ctrlIdle` high and closes all rows right afterwards, except in the single case that checks that a change is ignored.

// File: rtl/sdram_map_pkg.sv
package sdram_map_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PREA = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6
  } memCmdE;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadCfg;
    logic capture;
    logic openRow;
  } mapStrobeS;

endpackage

// File: rtl/map_tracker_ctrl.sv
module map_tracker_ctrl
  import sdram_map_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlIdle,
  input  logic      reqValid,
  input  memCmdE    cmd,
  output mapStrobeS stb,
  output logic      openValid,
  output logic      prevValid,
  output logic      accValid
);

  logic closeRow;

  always_comb begin
    stb.loadCfg = ctrlIdle;
    stb.capture = reqValid;
    stb.openRow = (cmd == CMD_ACT);
    closeRow    = (cmd == CMD_PREA) || (cmd == CMD_REF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= 1'b0;
      prevValid <= 1'b0;
      accValid  <= 1'b0;
    end else begin
      if (closeRow)
        openValid <= 1'b0;
      else if (stb.openRow)
        openValid <= 1'b1;
      if (reqValid)
        prevValid <= 1'b1;
      accValid <= reqValid;
    end
  end

endmodule

// File: rtl/addr_split_dp.sv
module addr_split_dp
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W       = 26,
  parameter int ROW_W        = 13,
  parameter int MIN_COL_BITS = 8,
  parameter int PAGE_OPTS    = 4,
  parameter int A10_POS      = 10,
  localparam int COL_W       = MIN_COL_BITS + PAGE_OPTS - 1,
  localparam int PAGE_SEL_W  = $clog2(PAGE_OPTS),
  localparam int BANK_W      = 2,
  localparam int PIN_W       = ROW_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mapStrobeS             stb,
  input  logic                  openValid,
  input  logic                  prevValid,
  input  logic [PAGE_SEL_W-1:0] cfgPageSel,
  input  logic                  cfgFourBanks,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  memCmdE                cmd,
  output logic [COL_W-1:0]      colOut,
  output logic [ROW_W-1:0]      rowOut,
  output logic [BANK_W-1:0]     bankOut,
  output logic                  hit,
  output logic                  miss,
  output logic                  seq,
  output logic [PIN_W-1:0]      pinAddr,
  output logic                  pinA10,
  output logic                  pinBankLo,
  output logic                  pinBankHi
);

  localparam int SHIFT_W = $clog2(ADDR_W + 1);

  logic [PAGE_SEL_W-1:0] pageSelQ;
  logic                  fourQ;
  logic [SHIFT_W-1:0]    colBits, rowShift;
  logic [ADDR_W-1:0]     colMask;
  logic [COL_W-1:0]      colNow;
  logic [BANK_W-1:0]     bankRaw, bankNow;
  logic [ROW_W-1:0]      rowNow;
  logic                  hitNow, seqNow;

  logic [COL_W-1:0]      curCol;
  logic [ROW_W-1:0]      curRow;
  logic [BANK_W-1:0]     curBank;
  logic [ADDR_W-1:0]     prevAddr;
  logic [ROW_W-1:0]      openRowQ;
  logic [BANK_W-1:0]     openBankQ;
  logic [PIN_W-1:0]      rowPins, colPins;

  // configuration, sampled only while the sequencer is idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageSelQ <= '0;
      fourQ    <= 1'b0;
    end else if (stb.loadCfg) begin
      pageSelQ <= cfgPageSel;
      fourQ    <= cfgFourBanks;
    end
  end

  // field split: column at the bottom, bank right above, row above that
  always_comb begin
    colBits  = SHIFT_W'(MIN_COL_BITS) + SHIFT_W'(pageSelQ);
    rowShift = colBits + (fourQ ? SHIFT_W'(2) : SHIFT_W'(1));
    colMask  = ~({ADDR_W{1'b1}} << colBits);
    colNow   = COL_W'(reqAddr & colMask);
    bankRaw  = BANK_W'(reqAddr >> colBits);
    bankNow  = fourQ ? bankRaw : {1'b0, bankRaw[0]};
    rowNow   = ROW_W'(reqAddr >> rowShift);
    hitNow   = openValid && (bankNow == openBankQ) && (rowNow == openRowQ);
    // next word of the same page: the column must not have wrapped to zero
    seqNow   = prevValid && (reqAddr == prevAddr + ADDR_W'(1)) && (colNow != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCol    <= '0;
      curRow    <= '0;
      curBank   <= '0;
      prevAddr  <= '0;
      openRowQ  <= '0;
      openBankQ <= '0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      seq       <= 1'b0;
    end else begin
      if (stb.capture) begin
        curCol   <= colNow;
        curRow   <= rowNow;
        curBank  <= bankNow;
        prevAddr <= reqAddr;
      end
      if (stb.openRow) begin
        openRowQ  <= curRow;
        openBankQ <= curBank;
      end
      hit  <= stb.capture && hitNow;
      miss <= stb.capture && !hitNow;
      seq  <= stb.capture && seqNow;
    end
  end

  // pin images: the A10 slot of the bus is never used, A10 has its own line
  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    if (p == A10_POS) begin : g_slot
      assign rowPins[p] = 1'b0;
      assign colPins[p] = 1'b0;
    end else begin : g_bit
      assign rowPins[p] = curRow[p];
      if (p < A10_POS) begin : g_lowCol
        assign colPins[p] = curCol[p];
      end else if (p - 1 < COL_W) begin : g_highCol
        assign colPins[p] = curCol[p-1];
      end else begin : g_noCol
        assign colPins[p] = 1'b0;
      end
    end
  end

  always_comb begin
    pinAddr   = '0;
    pinA10    = 1'b0;
    pinBankLo = 1'b0;
    pinBankHi = 1'b0;
    unique case (cmd)
      CMD_ACT: begin
        pinAddr   = rowPins;
        pinA10    = curRow[A10_POS];
        pinBankLo = curBank[0];
        pinBankHi = curBank[1];
      end
      CMD_MRS: begin
        pinAddr = rowPins;
        pinA10  = curRow[A10_POS];
      end
      CMD_RD, CMD_WR: begin
        pinAddr   = colPins;
        pinBankLo = curBank[0];
        pinBankHi = curBank[1];
      end
      CMD_PREA: pinA10 = 1'b1;
      default: ;
    endcase
  end

  assign colOut  = curCol;
  assign rowOut  = curRow;
  assign bankOut = curBank;

endmodule

// File: rtl/sdram_page_mapper.sv
module sdram_page_mapper
  import sdram_map_pkg::*;
#(
  parameter int ADDR_W       = 26,
  parameter int ROW_W        = 13,
  parameter int MIN_COL_BITS = 8,
  parameter int PAGE_OPTS    = 4,
  parameter int A10_POS      = 10,
  localparam int COL_W       = MIN_COL_BITS + PAGE_OPTS - 1,
  localparam int PAGE_SEL_W  = $clog2(PAGE_OPTS),
  localparam int BANK_W      = 2,
  localparam int PIN_W       = ROW_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PAGE_SEL_W-1:0] cfgPageSel,
  input  logic                  cfgFourBanks,
  input  logic                  ctrlIdle,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [2:0]            cmd,
  output logic                  accValid,
  output logic [COL_W-1:0]      colOut,
  output logic [ROW_W-1:0]      rowOut,
  output logic [BANK_W-1:0]     bankOut,
  output logic                  hit,
  output logic                  miss,
  output logic                  seq,
  output logic [PIN_W-1:0]      pinAddr,
  output logic                  pinA10,
  output logic                  pinBankLo,
  output logic                  pinBankHi
);

  mapStrobeS stb;
  logic      openValid, prevValid;
  memCmdE    cmdE;

  assign cmdE = memCmdE'(cmd);

  map_tracker_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIdle  (ctrlIdle),
    .reqValid  (reqValid),
    .cmd       (cmdE),
    .stb       (stb),
    .openValid (openValid),
    .prevValid (prevValid),
    .accValid  (accValid)
  );

  addr_split_dp #(
    .ADDR_W       (ADDR_W),
    .ROW_W        (ROW_W),
    .MIN_COL_BITS (MIN_COL_BITS),
    .PAGE_OPTS    (PAGE_OPTS),
    .A10_POS      (A10_POS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .openValid    (openValid),
    .prevValid    (prevValid),
    .cfgPageSel   (cfgPageSel),
    .cfgFourBanks (cfgFourBanks),
    .reqAddr      (reqAddr),
    .cmd          (cmdE),
    .colOut       (colOut),
    .rowOut       (rowOut),
    .bankOut      (bankOut),
    .hit          (hit),
    .miss         (miss),
    .seq          (seq),
    .pinAddr      (pinAddr),
    .pinA10       (pinA10),
    .pinBankLo    (pinBankLo),
    .pinBankHi    (pinBankHi)
  );

endmodule

// File: rtl/sdram_page_mapper_chk.sv
module sdram_page_mapper_chk #(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 11,
  parameter int A10_POS = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [2:0]       cmd,
  input logic             accValid,
  input logic [COL_W-1:0] colOut,
  input logic [ROW_W-1:0] rowOut,
  input logic             hit,
  input logic             miss,
  input logic             seq,
  input logic [ROW_W-1:0] pinAddr,
  input logic             pinA10,
  input logic             pinBankLo,
  input logic             pinBankHi
);

  logic [ROW_W-1:0] rowFromPins;
  logic [COL_W-1:0] colFromPins;
  logic             isAct, isMrs, isRdWr, isPrea, isQuiet, isClose;

  always_comb begin
    rowFromPins          = pinAddr;
    rowFromPins[A10_POS] = pinA10;
    for (int i = 0; i < COL_W; i++)
      colFromPins[i] = (i < A10_POS) ? pinAddr[i] : pinAddr[i+1];
    isAct   = (cmd == 3'd1);
    isMrs   = (cmd == 3'd6);
    isRdWr  = (cmd == 3'd2) || (cmd == 3'd3);
    isPrea  = (cmd == 3'd4);
    isQuiet = (cmd == 3'd0) || (cmd == 3'd5);
    isClose = isPrea || (cmd == 3'd5);
  end

  AST_ACC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> accValid); // R12
  AST_NO_ACC_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !accValid); // R12
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (hit ^ miss)); // R8
  AST_FLAGS_NEED_ACC: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !hit && !miss && !seq); // R8
  AST_CLOSE_FORCES_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (isClose ##1 reqValid) |=> miss); // R9
  AST_ROW_ON_PINS: assert property (@(posedge clk) disable iff (!rstN)
    (isAct || isMrs) |-> rowFromPins == rowOut); // R5
  AST_A10_SLOT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !pinAddr[A10_POS]); // R5
  AST_COL_ON_PINS: assert property (@(posedge clk) disable iff (!rstN)
    isRdWr |-> colFromPins == colOut && !pinA10 && !pinAddr[ROW_W-1]); // R6
  AST_PREA_A10_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    isPrea |-> pinA10 && pinAddr == '0); // R7
  AST_QUIET_PINS: assert property (@(posedge clk) disable iff (!rstN)
    isQuiet |-> !pinA10 && pinAddr == '0); // R7
  AST_BANK_PIN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !(isAct || isRdWr) |-> !pinBankLo && !pinBankHi); // R4

endmodule

bind sdram_page_mapper sdram_page_mapper_chk #(
  .ROW_W   (ROW_W),
  .COL_W   (COL_W),
  .A10_POS (A10_POS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .cmd       (cmd),
  .accValid  (accValid),
  .colOut    (colOut),
  .rowOut    (rowOut),
  .hit       (hit),
  .miss      (miss),
  .seq       (seq),
  .pinAddr   (pinAddr),
  .pinA10    (pinA10),
  .pinBankLo (pinBankLo),
  .pinBankHi (pinBankHi)
);

// File: tb/sdram_page_mapper_bench.sv
module sdram_page_mapper_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] AMASK = 32'h03FF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgPageSel = 2'd0;
  logic        cfgFourBanks = 1'b0;
  logic        ctrlIdle = 1'b0;
  logic        reqValid = 1'b0;
  logic [25:0] reqAddr = '0;
  logic [2:0]  cmd = 3'd0;
  logic        accValid, hit, miss, seq, pinA10, pinBankLo, pinBankHi;
  logic [10:0] colOut;
  logic [12:0] rowOut, pinAddr;
  logic [1:0]  bankOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_page_mapper u_sdram_page_mapper (
    .clk(clk), .rstN(rstN), .cfgPageSel(cfgPageSel), .cfgFourBanks(cfgFourBanks),
    .ctrlIdle(ctrlIdle), .reqValid(reqValid), .reqAddr(reqAddr), .cmd(cmd),
    .accValid(accValid), .colOut(colOut), .rowOut(rowOut), .bankOut(bankOut),
    .hit(hit), .miss(miss), .seq(seq), .pinAddr(pinAddr), .pinA10(pinA10),
    .pinBankLo(pinBankLo), .pinBankHi(pinBankHi)
  );

  int checks = 0;
  int fails  = 0;

  // bench model
  int          mPage = 0;
  bit          mFour = 1'b0;
  bit          mOpenV = 1'b0;
  logic [31:0] mOpenBank = 0, mOpenRow = 0;
  bit          mPrevV = 1'b0;
  logic [31:0] mPrev = 0;
  logic [31:0] lastCol = 0, lastBank = 0, lastRow = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic setCfg(input int pg, input bit four);
    @(negedge clk);
    cfgPageSel = 2'(pg); cfgFourBanks = four; ctrlIdle = 1'b1;
    @(negedge clk);
    ctrlIdle = 1'b0;
    mPage = pg; mFour = four;
  endtask

  task automatic doReq(input logic [31:0] a);
    int cb, nb;
    logic [31:0] eCol, eBank, eRow;
    bit eHit, eSeq;
    cb = 8 + mPage;
    nb = mFour ? 2 : 1;
    eCol  = a & ((32'd1 << cb) - 1);
    eBank = (a >> cb) & (mFour ? 32'd3 : 32'd1);
    eRow  = (a >> (cb + nb)) & 32'h1FFF;
    eHit  = mOpenV && (eBank == mOpenBank) && (eRow == mOpenRow);
    eSeq  = mPrevV && (a == ((mPrev + 1) & AMASK)) && ((a >> cb) == (mPrev >> cb));
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 26'(a);
    @(negedge clk);
    reqValid = 1'b0;
    chkEq("R12 accValid", 32'(accValid), 32'd1);
    chkEq("R1 column", 32'(colOut), eCol);
    chkEq("R2 bank", 32'(bankOut), eBank);
    chkEq("R3 row", 32'(rowOut), eRow);
    chkEq("R8 hit", 32'(hit), 32'(eHit));
    chkEq("R8 miss", 32'(miss), 32'(!eHit));
    chkEq("R10 seq", 32'(seq), 32'(eSeq));
    mPrevV = 1'b1; mPrev = a;
    lastCol = eCol; lastBank = eBank; lastRow = eRow;
  endtask

  task automatic doCmd(input logic [2:0] c);
    logic [31:0] eAddr, eA10, eLo, eHi;
    eAddr = 0; eA10 = 0; eLo = 0; eHi = 0;
    case (c)
      3'd1, 3'd6: begin
        eAddr = lastRow & 32'h1BFF;
        eA10  = (lastRow >> 10) & 1;
        if (c == 3'd1) begin eLo = lastBank & 1; eHi = (lastBank >> 1) & 1; end
      end
      3'd2, 3'd3: begin
        eAddr = (lastCol & 32'h3FF) | (((lastCol >> 10) & 1) << 11);
        eLo = lastBank & 1; eHi = (lastBank >> 1) & 1;
      end
      3'd4: eA10 = 1;
      default: ;
    endcase
    cmd = c;
    #1;
    chkEq((c == 3'd1 || c == 3'd6) ? "R5 pin address" :
          (c == 3'd2 || c == 3'd3) ? "R6 pin address" : "R7 pin address",
          32'(pinAddr), eAddr);
    chkEq((c == 3'd4) ? "R7 a10 line" : "R5 R6 a10 line", 32'(pinA10), eA10);
    chkEq("R4 bank line lo", 32'(pinBankLo), eLo);
    chkEq("R4 bank line hi", 32'(pinBankHi), eHi);
    @(negedge clk);
    cmd = 3'd0;
    if (c == 3'd1) begin mOpenV = 1'b1; mOpenBank = lastBank; mOpenRow = lastRow; end
    if (c == 3'd4 || c == 3'd5) mOpenV = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0h exp=%0h", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] a, base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chkEq("R12 reset accValid", 32'(accValid), 0);
    chkEq("R12 reset hit", 32'(hit), 0);
    chkEq("R12 reset miss", 32'(miss), 0);
    chkEq("R12 reset seq", 32'(seq), 0);
    chkEq("R12 reset pins", {17'd0, pinA10, pinBankLo, pinAddr}, 0);

    // sweep every configuration
    for (int pg = 0; pg < 4; pg++) begin
      for (int fb = 0; fb < 2; fb++) begin
        setCfg(pg, fb[0]);
        doCmd(3'd4);
        for (int k = 0; k < 24; k++) begin
          a = nextRand() & AMASK;
          if (a == AMASK) a = a - 1;
          doReq(a);
          if (!mOpenV || !((lastBank == mOpenBank) && (lastRow == mOpenRow)))
            doCmd(3'd1);
          doCmd(k[0] ? 3'd2 : 3'd3);
          if (k % 3 == 0) begin
            doReq(a + 1);
            doCmd(3'd2);
          end
          if (k % 7 == 6) doCmd(3'd5);
          if (k % 8 == 5) doCmd(3'd6);
        end
      end
    end

    // R10: wrap at the page boundary, 256-word pages, four banks
    setCfg(0, 1'b1);
    doCmd(3'd4);
    base = 32'h0001_2300;
    doReq(base + 254);
    doCmd(3'd1);
    doReq(base + 255);
    chkEq("R10 seq inside page", 32'(seq), 1);
    doReq(base);
    chkEq("R10 wrap stays hit", 32'(hit), 1);
    chkEq("R10 wrap not sequential", 32'(seq), 0);
    doReq(base + 1);
    chkEq("R10 seq after wrap", 32'(seq), 1);
    doReq(base + 256);
    chkEq("R10 next page not sequential", 32'(seq), 0);

    // R8: same row, other bank is a miss
    doReq((32'd5 << 10) | 32'd3);
    doCmd(3'd1);
    doReq((32'd5 << 10) | 32'd7);
    chkEq("R8 same bank and row hit", 32'(hit), 1);
    doReq((32'd5 << 10) | (32'd1 << 8) | 32'd7);
    chkEq("R8 off bank miss", 32'(miss), 1);
    doReq((32'd6 << 10) | 32'd7);
    chkEq("R8 off row miss", 32'(miss), 1);

    // R9: refresh closes the open row
    doReq((32'd5 << 10) | 32'd9);
    chkEq("R9 hit before close", 32'(hit), 1);
    doCmd(3'd5);
    doReq((32'd5 << 10) | 32'd9);
    chkEq("R9 miss after refresh", 32'(miss), 1);
    doCmd(3'd1);
    doCmd(3'd4);
    doReq((32'd5 << 10) | 32'd9);
    chkEq("R9 miss after precharge", 32'(miss), 1);

    // R11: configuration change without idle is ignored
    @(negedge clk);
    cfgPageSel = 2'd3; cfgFourBanks = 1'b0;
    doReq(32'h0000_0FFF);
    chkEq("R11 column unchanged", 32'(colOut), 32'hFF);
    chkEq("R11 bank unchanged", 32'(bankOut), 32'd3);
    cfgPageSel = 2'd0; cfgFourBanks = 1'b1;

    // R12: accValid drops one cycle later
    @(negedge clk);
    chkEq("R12 accValid low", 32'(accValid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule